// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block sits next to a small 8-bit processor core and owns its three power states: RUN, HALT and STOP. It watches the opcodes the core issues at instruction boundaries. A halt opcode (7Fh) or a stop opcode (6Fh, a parameter) is honoured only when the opcode accepted just before it was a NOP (FFh), so the core is never frozen in the middle of an instruction. The block then drives registered clock-enable strobes instead of gating clocks with logic: one strobe for the core, one for the timers and interrupt logic, and an enable for the oscillator.

In HALT only the core strobe stops, so timers and interrupts keep running. An enabled interrupt wakes the core, which resumes at the instruction after the halt. A reset or watchdog request also wakes it, but execution then restarts at a fixed vector, and reset wins when both arrive in the same cycle. STOP turns off the oscillator and every strobe. Only a reset or watchdog request ends it, followed by a fixed settling interval before the clocks return. A two-bit scale setting divides the internal clock by 1, 2, 4 or 8. It may be rewritten at any time, and a new setting is adopted only at the end of the current divided period.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is asserted and afterwards, the block is in RUN with the scale set to 0 (divide by 1): osc_en=1, resume_in_place=0, restart_vec=000Ch, resume_stb=0, and cpu_clk_en is high on every cycle after reset is released.
- R2: A valid opcode 7Fh enters HALT only when the previous valid opcode was FFh. Idle cycles between the two do not count. A 7Fh after any other opcode is ignored.
- R3: In HALT, cpu_clk_en stays low, osc_en stays high and periph_clk_en keeps pulsing at the divided rate. cpu_clk_en is never high while periph_clk_en is low.
- R4: In HALT, an interrupt request with no reset or watchdog request gives a one-cycle resume_stb with resume_in_place=1 on the next cycle, and the core strobe resumes.
- R5: In HALT, a reset or watchdog request gives resume_stb with resume_in_place=0 and restart_vec=000Ch.
- R6: When an interrupt and a reset or watchdog request arrive in the same HALT cycle, the result is that of R5.
- R7: A valid opcode 6Fh that follows a valid FFh enters STOP. From the next cycle, osc_en, cpu_clk_en and periph_clk_en are all low.
- R8: In STOP, interrupt requests have no effect: osc_en stays low and no resume_stb is given.
- R9: In STOP, a reset or watchdog request raises osc_en on the next cycle. resume_stb (with resume_in_place=0) follows exactly STAB_CYCLES cycles after that first cycle, and both clock strobes stay low until then.
- R10: Scale value s (0..3, written through scale_wr and scale_in) makes the strobes pulse once every 2^s cycles.
- R11: A scale write, accepted in RUN or HALT, takes effect only once the divided period in progress has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low power-on reset |
| instr_valid | input | 1 | An opcode is issued at an instruction boundary |
| instr_op | input | 8 | Issued opcode |
| irq_wake | input | 1 | An enabled interrupt is pending |
| ext_reset_req | input | 1 | External reset request |
| wdt_timeout | input | 1 | Watchdog time-out |
| scale_wr | input | 1 | Write strobe for the clock scale field |
| scale_in | input | SCALE_W | New clock scale value |
| cpu_clk_en | output | 1 | Core clock-enable strobe |
| periph_clk_en | output | 1 | Timer and interrupt clock-enable strobe |
| osc_en | output | 1 | Oscillator enable |
| resume_stb | output | 1 | One-cycle pulse when the core may resume |
| resume_in_place | output | 1 | 1: continue after the halt; 0: restart at restart_vec |
| restart_vec | output | 16 | Restart address for the last wake |

## Verification
Several rules are checked on every cycle by the assertions: the core strobe always implies the peripheral strobe, all strobes are quiet while the oscillator is off, reset wins over an interrupt in HALT, STOP cannot be left without a reset or watchdog request, the divider count stays inside its period, and the scale changes only at a period end. Other behaviour can only be shown by the bench's scenarios: the NOP-before-halt ordering, the pulse rates for each scale value, a scale rewritten while halted, and the exact length of the settling interval after STOP. A behavioural model compares every output on every cycle against these scenarios.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_HALT = 2'd1,
    PM_STOP = 2'd2,
    PM_WAKE = 2'd3
  } pm_state_e;

  // The divided internal clock runs only while the oscillator is settled and on
  function automatic logic clocks_alive(input pm_state_e s);
    return (s == PM_RUN) || (s == PM_HALT);
  endfunction

endpackage

// File: rtl/pwr_op_decode.sv
module pwr_op_decode #(
  parameter logic [7:0] NOP_OP  = 8'hFF,
  parameter logic [7:0] HALT_OP = 8'h7F,
  parameter logic [7:0] STOP_OP = 8'h6F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       instr_valid,
  input  logic [7:0] instr_op,
  input  logic       in_run,
  output logic       halt_req,
  output logic       stop_req
);

  logic nop_prev;
  logic boundary_ok;

  // Remembers whether the last accepted opcode drained the pipeline
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          nop_prev <= 1'b0;
    else if (instr_valid) nop_prev <= (instr_op == NOP_OP);
  end

  assign boundary_ok = in_run && instr_valid && nop_prev;
  assign halt_req    = boundary_ok && (instr_op == HALT_OP);
  assign stop_req    = boundary_ok && (instr_op == STOP_OP);

  // R2
  one_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(halt_req && stop_req));

endmodule

// File: rtl/pwr_clk_div.sv
module pwr_clk_div #(
  parameter int SCALE_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic               scale_wr,
  input  logic [SCALE_W-1:0] scale_in,
  output logic               tick
);

  localparam int DIV_CW = (1 << SCALE_W) - 1;

  // Last count value of a period for a given scale: 2^s - 1
  function automatic logic [DIV_CW-1:0] last_count(input logic [SCALE_W-1:0] s);
    logic [DIV_CW:0] span;
    span = {{DIV_CW{1'b0}}, 1'b1} << s;
    return DIV_CW'(span - 1'b1);
  endfunction

  logic [SCALE_W-1:0] scale_req;
  logic [SCALE_W-1:0] scale_act;
  logic [DIV_CW-1:0]  cnt;
  logic               period_end;
  logic               adopt_ok;

  assign period_end = (cnt == last_count(scale_act));
  assign tick       = active && period_end;
  assign adopt_ok   = !active || period_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scale_req <= '0;
      scale_act <= '0;
      cnt       <= '0;
    end else begin
      if (scale_wr) scale_req <= scale_in;
      if (adopt_ok) begin
        cnt       <= '0;
        scale_act <= scale_req;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R10
  cnt_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last_count(scale_act));

  // R11
  scale_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scale_act != $past(scale_act)) |-> $past(adopt_ok));

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_pkg::*;
#(
  parameter int          STAB_CYCLES = 16,
  parameter logic [15:0] RESET_VEC   = 16'h000C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        halt_req,
  input  logic        stop_req,
  input  logic        irq_wake,
  input  logic        rst_wake,
  output pm_state_e   state,
  output pm_state_e   nxt_state,
  output logic        resume_stb,
  output logic        resume_in_place,
  output logic [15:0] restart_vec
);

  localparam int             WCW       = (STAB_CYCLES > 1) ? $clog2(STAB_CYCLES) : 1;
  localparam logic [WCW-1:0] WAKE_LAST = WCW'(STAB_CYCLES - 1);

  logic [WCW-1:0] wake_cnt;
  logic           stab_done;
  logic           wake_evt;
  logic           wake_here;

  assign stab_done = (wake_cnt == WAKE_LAST);

  always_comb begin
    nxt_state = state;
    wake_evt  = 1'b0;
    wake_here = 1'b0;
    case (state)
      PM_RUN: begin
        if (halt_req)      nxt_state = PM_HALT;
        else if (stop_req) nxt_state = PM_STOP;
      end
      PM_HALT: begin
        if (rst_wake) begin
          nxt_state = PM_RUN;
          wake_evt  = 1'b1;
        end else if (irq_wake) begin
          nxt_state = PM_RUN;
          wake_evt  = 1'b1;
          wake_here = 1'b1;
        end
      end
      PM_STOP: begin
        if (rst_wake) nxt_state = PM_WAKE;
      end
      PM_WAKE: begin
        if (stab_done) begin
          nxt_state = PM_RUN;
          wake_evt  = 1'b1;
        end
      end
      default: nxt_state = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state           <= PM_RUN;
      wake_cnt        <= '0;
      resume_stb      <= 1'b0;
      resume_in_place <= 1'b0;
      restart_vec     <= RESET_VEC;
    end else begin
      state      <= nxt_state;
      resume_stb <= wake_evt;
      if (state == PM_WAKE) wake_cnt <= wake_cnt + 1'b1;
      else                  wake_cnt <= '0;
      if (wake_evt) begin
        resume_in_place <= wake_here;
        restart_vec     <= wake_here ? 16'h0000 : RESET_VEC;
      end
    end
  end

  // R4
  irq_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_HALT && irq_wake && !rst_wake) |=> (resume_stb && resume_in_place && state == PM_RUN));

  // R5
  restart_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_stb && !resume_in_place) |-> (restart_vec == RESET_VEC));

  // R6
  rst_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_HALT && rst_wake && irq_wake) |=> (resume_stb && !resume_in_place));

  // R8
  stop_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_STOP && !rst_wake) |=> (state == PM_STOP && !resume_stb));

  // R9
  settle_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_stb && $past(state) == PM_WAKE) |-> ($past(wake_cnt) == WAKE_LAST));

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_pkg::*;
#(
  parameter int          SCALE_W     = 2,
  parameter int          STAB_CYCLES = 16,
  parameter logic [15:0] RESET_VEC   = 16'h000C,
  parameter logic [7:0]  NOP_OP      = 8'hFF,
  parameter logic [7:0]  HALT_OP     = 8'h7F,
  parameter logic [7:0]  STOP_OP     = 8'h6F
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  input  logic [7:0]         instr_op,
  input  logic               irq_wake,
  input  logic               ext_reset_req,
  input  logic               wdt_timeout,
  input  logic               scale_wr,
  input  logic [SCALE_W-1:0] scale_in,
  output logic               cpu_clk_en,
  output logic               periph_clk_en,
  output logic               osc_en,
  output logic               resume_stb,
  output logic               resume_in_place,
  output logic [15:0]        restart_vec
);

  pm_state_e state;
  pm_state_e nxt_state;
  logic      halt_req;
  logic      stop_req;
  logic      rst_wake;
  logic      in_run;
  logic      div_active;
  logic      div_tick;

  assign rst_wake   = ext_reset_req || wdt_timeout;
  assign in_run     = (state == PM_RUN);
  assign div_active = clocks_alive(state);

  pwr_op_decode #(
    .NOP_OP  (NOP_OP),
    .HALT_OP (HALT_OP),
    .STOP_OP (STOP_OP)
  ) u_decode (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_op    (instr_op),
    .in_run      (in_run),
    .halt_req    (halt_req),
    .stop_req    (stop_req)
  );

  pwr_clk_div #(
    .SCALE_W (SCALE_W)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (div_active),
    .scale_wr (scale_wr),
    .scale_in (scale_in),
    .tick     (div_tick)
  );

  pwr_mode_fsm #(
    .STAB_CYCLES (STAB_CYCLES),
    .RESET_VEC   (RESET_VEC)
  ) u_fsm (
    .clk             (clk),
    .rst_n           (rst_n),
    .halt_req        (halt_req),
    .stop_req        (stop_req),
    .irq_wake        (irq_wake),
    .rst_wake        (rst_wake),
    .state           (state),
    .nxt_state       (nxt_state),
    .resume_stb      (resume_stb),
    .resume_in_place (resume_in_place),
    .restart_vec     (restart_vec)
  );

  // Registered enables: each is a clean full-cycle level for a downstream clock gate
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_clk_en    <= 1'b0;
      periph_clk_en <= 1'b0;
      osc_en        <= 1'b1;
    end else begin
      cpu_clk_en    <= div_tick && (nxt_state == PM_RUN);
      periph_clk_en <= div_tick && clocks_alive(nxt_state);
      osc_en        <= (nxt_state != PM_STOP);
    end
  end

  // R3
  cpu_needs_periph_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en |-> periph_clk_en);

  // R3
  halt_keeps_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_HALT) |-> (osc_en && !cpu_clk_en));

  // R7
  osc_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> (!cpu_clk_en && !periph_clk_en));

endmodule

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;

  localparam int          STAB = 16;
  localparam logic [15:0] RVEC = 16'h000C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       instr_valid = 1'b0;
  logic [7:0] instr_op = 8'h00;
  logic       irq_wake = 1'b0;
  logic       ext_reset_req = 1'b0;
  logic       wdt_timeout = 1'b0;
  logic       scale_wr = 1'b0;
  logic [1:0] scale_in = 2'd0;
  logic       cpu_clk_en, periph_clk_en, osc_en, resume_stb, resume_in_place;
  logic [15:0] restart_vec;

  always #10 clk = ~clk;

  pwr_mode_ctrl #(.STAB_CYCLES(STAB)) dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_op(instr_op),
    .irq_wake(irq_wake), .ext_reset_req(ext_reset_req), .wdt_timeout(wdt_timeout),
    .scale_wr(scale_wr), .scale_in(scale_in), .cpu_clk_en(cpu_clk_en),
    .periph_clk_en(periph_clk_en), .osc_en(osc_en), .resume_stb(resume_stb),
    .resume_in_place(resume_in_place), .restart_vec(restart_vec)
  );

  int    checks = 0;
  int    failures = 0;
  string phase = "R1";
  bit    done = 0;

  // Behavioural reference: 0 run, 1 halt, 2 stop, 3 settling
  int  m_st, m_nst, m_div, m_sa, m_sr, m_wc;
  bit  m_pnop, m_tk, m_rw;
  bit  m_cpu, m_per, m_osc, m_stb, m_inp;
  logic [15:0] m_vec;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_pnop = 0; m_div = 0; m_sa = 0; m_sr = 0; m_wc = 0;
      m_cpu = 0; m_per = 0; m_osc = 1; m_stb = 0; m_inp = 0; m_vec = RVEC;
    end else begin
      m_rw  = ext_reset_req || wdt_timeout;
      m_tk  = (m_st < 2) && (m_div == (1 << m_sa) - 1);
      m_nst = m_st;
      m_stb = 0;
      if (m_st == 0) begin
        if (instr_valid && m_pnop && instr_op == 8'h7F) m_nst = 1;
        else if (instr_valid && m_pnop && instr_op == 8'h6F) m_nst = 2;
      end else if (m_st == 1) begin
        if (m_rw) begin m_nst = 0; m_stb = 1; m_inp = 0; end
        else if (irq_wake) begin m_nst = 0; m_stb = 1; m_inp = 1; end
      end else if (m_st == 2) begin
        if (m_rw) begin m_nst = 3; m_wc = 0; end
      end else begin
        if (m_wc == STAB - 1) begin m_nst = 0; m_stb = 1; m_inp = 0; end
        else m_wc++;
      end
      if (m_stb) m_vec = m_inp ? 16'h0000 : RVEC;
      if (instr_valid) m_pnop = (instr_op == 8'hFF);
      if (m_st >= 2 || m_tk) begin m_div = 0; m_sa = m_sr; end
      else m_div++;
      if (scale_wr) m_sr = int'(scale_in);
      m_cpu = m_tk && (m_nst == 0);
      m_per = m_tk && (m_nst < 2);
      m_osc = (m_nst != 2);
      m_st  = m_nst;
    end
  end

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (cpu_clk_en !== m_cpu || periph_clk_en !== m_per || osc_en !== m_osc ||
          resume_stb !== m_stb || resume_in_place !== m_inp || restart_vec !== m_vec) begin
        failures++;
        $display("FAIL %s model compare: actual cpu=%b per=%b osc=%b stb=%b inp=%b vec=%h expected cpu=%b per=%b osc=%b stb=%b inp=%b vec=%h",
                 phase, cpu_clk_en, periph_clk_en, osc_en, resume_stb, resume_in_place, restart_vec,
                 m_cpu, m_per, m_osc, m_stb, m_inp, m_vec);
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(input logic [7:0] op);
    instr_valid = 1'b1; instr_op = op;
    @(negedge clk);
    instr_valid = 1'b0; instr_op = 8'h00;
  endtask

  task automatic set_scale(input logic [1:0] s);
    scale_wr = 1'b1; scale_in = s;
    @(negedge clk);
    scale_wr = 1'b0;
  endtask

  task automatic count_pulses(input int n, output int c_cpu, output int c_per);
    c_cpu = 0; c_per = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      c_cpu += int'(cpu_clk_en);
      c_per += int'(periph_clk_en);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int c_cpu, c_per, n;
    // R1 reset values
    cyc(3);
    chk("R1", "osc_en in reset", int'(osc_en), 1);
    chk("R1", "cpu_clk_en in reset", int'(cpu_clk_en), 0);
    chk("R1", "restart_vec in reset", int'(restart_vec), int'(RVEC));
    chk("R1", "resume_in_place in reset", int'(resume_in_place), 0);
    rst_n = 1'b1;
    cyc(2);
    count_pulses(8, c_cpu, c_per);
    chk("R1", "cpu pulses at divide by 1", c_cpu, 8);

    // R10 each scale value
    phase = "R10";
    for (int s = 1; s < 4; s++) begin
      set_scale(2'(s));
      cyc(12);
      count_pulses(32, c_cpu, c_per);
      chk("R10", "cpu pulses per 32 cycles", c_cpu, 32 >> s);
    end
    set_scale(2'd0);
    cyc(10);

    // R2 halt without a preceding NOP is ignored
    phase = "R2";
    issue(8'h00);
    issue(8'h7F);
    count_pulses(4, c_cpu, c_per);
    chk("R2", "cpu pulses after lone 7Fh", c_cpu, 4);
    issue(8'hFF);
    cyc(2);
    issue(8'h7F);
    chk("R2", "cpu_clk_en after NOP then HALT", int'(cpu_clk_en), 0);

    // R3 halted: peripherals run at divided rate
    phase = "R3";
    set_scale(2'd1);
    cyc(12);
    count_pulses(32, c_cpu, c_per);
    chk("R3", "cpu pulses in HALT", c_cpu, 0);
    chk("R3", "periph pulses in HALT at divide by 2", c_per, 16);
    chk("R3", "osc_en in HALT", int'(osc_en), 1);

    // R11 rewrite scale while halted
    phase = "R11";
    set_scale(2'd3);
    cyc(12);
    count_pulses(32, c_cpu, c_per);
    chk("R11", "periph pulses after rewrite in HALT", c_per, 4);

    // R4 interrupt wake
    phase = "R4";
    irq_wake = 1'b1;
    @(negedge clk);
    irq_wake = 1'b0;
    chk("R4", "resume_stb", int'(resume_stb), 1);
    chk("R4", "resume_in_place", int'(resume_in_place), 1);
    cyc(1);
    chk("R4", "resume_stb one cycle", int'(resume_stb), 0);
    set_scale(2'd0);
    cyc(10);
    count_pulses(4, c_cpu, c_per);
    chk("R4", "cpu pulses after wake", c_cpu, 4);

    // R5 watchdog wake from HALT
    phase = "R5";
    issue(8'hFF);
    issue(8'h7F);
    cyc(3);
    wdt_timeout = 1'b1;
    @(negedge clk);
    wdt_timeout = 1'b0;
    chk("R5", "resume_stb", int'(resume_stb), 1);
    chk("R5", "resume_in_place", int'(resume_in_place), 0);
    chk("R5", "restart_vec", int'(restart_vec), int'(RVEC));
    cyc(4);

    // R6 reset beats interrupt
    phase = "R6";
    issue(8'hFF);
    issue(8'h7F);
    cyc(2);
    irq_wake = 1'b1; ext_reset_req = 1'b1;
    @(negedge clk);
    irq_wake = 1'b0; ext_reset_req = 1'b0;
    chk("R6", "resume_stb", int'(resume_stb), 1);
    chk("R6", "resume_in_place", int'(resume_in_place), 0);
    cyc(4);

    // R7 enter STOP
    phase = "R7";
    issue(8'hFF);
    issue(8'h6F);
    chk("R7", "osc_en after STOP", int'(osc_en), 0);
    chk("R7", "periph_clk_en after STOP", int'(periph_clk_en), 0);
    cyc(5);
    chk("R7", "cpu_clk_en in STOP", int'(cpu_clk_en), 0);

    // R8 interrupts ignored in STOP
    phase = "R8";
    irq_wake = 1'b1;
    count_pulses(4, c_cpu, c_per);
    irq_wake = 1'b0;
    chk("R8", "periph pulses with irq in STOP", c_per, 0);
    chk("R8", "osc_en with irq in STOP", int'(osc_en), 0);
    chk("R8", "resume_stb with irq in STOP", int'(resume_stb), 0);

    // R9 reset wake from STOP after settling
    phase = "R9";
    ext_reset_req = 1'b1;
    @(negedge clk);
    ext_reset_req = 1'b0;
    chk("R9", "osc_en after wake request", int'(osc_en), 1);
    n = 0;
    while (!resume_stb && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk("R9", "settling cycles before resume", n, STAB);
    chk("R9", "resume_in_place", int'(resume_in_place), 0);
    cyc(10);

    finish_run();
  end

endmodule